// File: doc/BRIEF.md
# Rotate Unit with Extend Flag

This execution unit rotates a byte, word or long operand left or right. It has two kinds of rotate. A plain rotate wraps the operand onto itself. An extend rotate passes the operand through a one-bit extend flag, so the ring is one bit wider than the operand. The unit decodes a 16-bit opcode to pick the operand size, the direction, the kind of rotate and the source of the count. The count comes either from a 3-bit immediate field or from the low bits of a count register, and a single-bit word form is provided for a memory operand. The operand, or the memory word, arrives on `data_i`. The result and the N, Z, V, C flags are combinational.

The extend flag lives in a register inside the unit. Every extend rotate reads it. An extend rotate presented with `valid_i` high writes the new value at the next rising clock edge. For byte and word sizes only the low bits of the destination change, and the rest of `data_i` passes through to `result_o`.

Top module: `rot_xunit`

## Requirements
- R1: A plain rotate reduces the raw count modulo the operand width (8, 16 or 32). An effective count of zero returns the operand unchanged.
- R2: An extend rotate reduces the raw count modulo the width plus one (9, 17 or 33).
- R3: An extend rotate right by a nonzero count k shifts the operand right by k and puts the old extend bit at position width−k. The low operand bits wrap in above it. The new extend bit is operand bit k−1.
- R4: An extend rotate left by a nonzero count k puts the old extend bit at position k−1, with the operand shifted up above it. The high operand bits wrap in below it. The new extend bit is operand bit width−k.
- R5: `z_o` is set when the sized result is zero. `n_o` copies the top bit of the sized result. `v_o` is always 0.
- R6: For a plain rotate, `c_o` equals result bit 0 on a left rotate and the result's top bit on a right rotate. `c_o` is 0 when the raw count is zero.
- R7: For an extend rotate, `c_o` equals the new extend bit. An effective count of zero leaves the extend bit unchanged, and `c_o` still copies it.
- R8: In the immediate form (opcode bit 5 = 0), opcode bits 11:9 hold the count 1 to 7, and the value 0 means 8.
- R9: In the register form (opcode bit 5 = 1), the count is bits 5:0 of `cnt_reg_i` (0 to 63). Higher bits are ignored.
- R10: Opcode bit 8 selects the direction: 1 is left, 0 is right. Opcode bit 3 selects the kind: 1 is plain, 0 is extend. Opcode bits 7:6 select the size: 00 byte, 01 word, 10 long. The value 11 selects the memory form, which is a word rotated by exactly 1.
- R11: For byte and word sizes, `result_o` carries `data_i` unchanged above the operand width.
- R12: The extend register resets to 0. It updates at a clock edge only when `valid_i` is high with an extend rotate. Plain rotates and cycles without `valid_i` leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; lets an extend rotate write the extend register |
| opcode_i | input | 16 | Rotate opcode |
| data_i | input | 32 | Destination register value or memory word |
| cnt_reg_i | input | 32 | Count register value for the register form |
| result_o | output | 32 | Rotated result, upper bits merged from data_i |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag, always 0 |
| c_o | output | 1 | Carry flag |
| x_o | output | 1 | Current extend register |

## Verification
The bench uses the default parameters: a 6-bit count mask and a 3-bit immediate field. This makes raw register counts up to 63 reachable, so counts that wrap several times round the 9-, 17- and 33-bit rings can be tested, along with a mask that discards bits of `cnt_reg_i` that are set. The 3-bit immediate field makes the value 0 meaning 8 reachable for every size. The bench's reference model rotates one bit per step, which is independent of the index arithmetic in the ring. It carries the extend bit from one operation to the next, so a stale or lost extend value shows up in later results.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } rot_size_e;

  localparam int CNT_W = 6;

  typedef struct packed {
    rot_size_e        size;
    logic             left;
    logic             plain;
    logic [CNT_W-1:0] cnt;
  } rot_op_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int IMM_W = 3
) (
  input  logic [15:0]      opcode_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  output rot_op_t          op_o
);
  localparam int IMM_LO = 9;
  localparam logic [CNT_W-1:0] IMM_ZERO_CNT = CNT_W'(1 << IMM_W);

  logic [IMM_W-1:0] imm_f;
  logic             mem_form;
  logic             unused_opc;

  assign imm_f      = opcode_i[IMM_LO +: IMM_W];
  assign mem_form   = (opcode_i[7:6] == 2'b11);
  assign unused_opc = ^{opcode_i[15:12], opcode_i[4], opcode_i[2:0]};

  always_comb begin
    op_o.left  = opcode_i[8];
    op_o.plain = opcode_i[3];
    if (mem_form) begin
      op_o.size = SZ_WORD;
      op_o.cnt  = CNT_W'(1);
    end else begin
      op_o.size = rot_size_e'(opcode_i[7:6]);
      if (opcode_i[5])          op_o.cnt = cnt_reg_i;
      else if (imm_f == '0)     op_o.cnt = IMM_ZERO_CNT;
      else                      op_o.cnt = CNT_W'(imm_f);
    end
  end
endmodule

// File: rtl/rot_ring.sv
module rot_ring
  import rot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             left_i,
  input  logic             plain_i,
  input  logic             x_i,
  output logic [W-1:0]     res_o,
  output logic             x_o,
  output logic             c_o
);
  localparam int RW = W + 1;

  int unsigned     kp, ke;
  logic [W-1:0]    p_res;
  logic [RW-1:0]   ring, e_out;

  assign kp   = int'(cnt_i) % W;
  assign ke   = int'(cnt_i) % RW;
  assign ring = {x_i, val_i};

  // plain ring: out[i] = in[(i +/- k) mod W]
  always_comb begin
    for (int i = 0; i < W; i++) begin
      int unsigned idx;
      idx = left_i ? (i + W - kp) : (i + kp);
      if (idx >= W) idx = idx - W;
      p_res[i] = val_i[idx];
    end
  end

  // extend ring: X sits at position W
  always_comb begin
    for (int i = 0; i < RW; i++) begin
      int unsigned idx;
      idx = left_i ? (i + RW - ke) : (i + ke);
      if (idx >= RW) idx = idx - RW;
      e_out[i] = ring[idx];
    end
  end

  always_comb begin
    if (plain_i) begin
      res_o = p_res;
      x_o   = x_i;
      if (cnt_i == '0) c_o = 1'b0;
      else             c_o = left_i ? p_res[0] : p_res[W-1];
    end else begin
      res_o = e_out[W-1:0];
      x_o   = e_out[W];
      c_o   = e_out[W];
    end
  end
endmodule

// File: rtl/rot_xunit.sv
module rot_xunit
  import rot_pkg::*;
#(
  parameter int IMM_W = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [15:0] opcode_i,
  input  logic [31:0] data_i,
  input  logic [31:0] cnt_reg_i,
  output logic [31:0] result_o,
  output logic        n_o,
  output logic        z_o,
  output logic        v_o,
  output logic        c_o,
  output logic        x_o
);
  localparam int DATA_W = 32;
  localparam int NUM_SZ = 3;

  rot_op_t           op;
  logic              x_q;
  logic [DATA_W-1:0] sz_res [NUM_SZ];
  logic              sz_x   [NUM_SZ];
  logic              sz_c   [NUM_SZ];
  logic [DATA_W-1:0] res_n;
  logic              msb, x_n, c_n;
  logic              unused_cnt;

  assign unused_cnt = ^cnt_reg_i[DATA_W-1:CNT_W];

  rot_decode #(.IMM_W(IMM_W)) u_dec (
    .opcode_i  (opcode_i),
    .cnt_reg_i (cnt_reg_i[CNT_W-1:0]),
    .op_o      (op)
  );

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int W = 8 << s;
    logic [W-1:0] r;
    rot_ring #(.W(W)) u_ring (
      .val_i   (data_i[W-1:0]),
      .cnt_i   (op.cnt),
      .left_i  (op.left),
      .plain_i (op.plain),
      .x_i     (x_q),
      .res_o   (r),
      .x_o     (sz_x[s]),
      .c_o     (sz_c[s])
    );
    assign sz_res[s] = DATA_W'(r);
  end

  always_comb begin
    case (op.size)
      SZ_BYTE: begin
        res_n = {data_i[DATA_W-1:8], sz_res[0][7:0]};
        msb   = sz_res[0][7];
        x_n   = sz_x[0];
        c_n   = sz_c[0];
      end
      SZ_WORD: begin
        res_n = {data_i[DATA_W-1:16], sz_res[1][15:0]};
        msb   = sz_res[1][15];
        x_n   = sz_x[1];
        c_n   = sz_c[1];
      end
      default: begin
        res_n = sz_res[2];
        msb   = sz_res[2][DATA_W-1];
        x_n   = sz_x[2];
        c_n   = sz_c[2];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   x_q <= 1'b0;
    else if (valid_i && !op.plain) x_q <= x_n;
  end

  assign result_o = res_n;
  assign n_o      = msb;
  assign z_o      = (op.size == SZ_BYTE) ? (res_n[7:0] == '0) :
                    (op.size == SZ_WORD) ? (res_n[15:0] == '0) : (res_n == '0);
  assign v_o      = 1'b0;
  assign c_o      = c_n;
  assign x_o      = x_q;
endmodule

// File: rtl/rot_xunit_chk.sv
module rot_xunit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [15:0] opcode_i,
  input logic [31:0] data_i,
  input logic [31:0] cnt_reg_i,
  input logic [31:0] result_o,
  input logic        n_o,
  input logic        z_o,
  input logic        c_o,
  input logic        x_o
);
  logic unused_chk;
  assign unused_chk = ^{opcode_i[15:9], opcode_i[4], opcode_i[2:0], cnt_reg_i[31:6]};

  AST_X_HOLD_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[3] |=> $stable(x_o)); // R12
  AST_X_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(x_o)); // R12
  AST_X_FROM_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !opcode_i[3] |=> x_o == $past(c_o)); // R7
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i[7:6] == 2'b00 |-> result_o[31:8] == data_i[31:8]); // R11
  AST_ZERO_CNT_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opcode_i[3] && opcode_i[5] && opcode_i[7:6] != 2'b11 && cnt_reg_i[5:0] == 6'd0
    |-> !c_o && result_o == data_i); // R6
  AST_ZERO_NOT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o |-> !n_o); // R5
endmodule

bind rot_xunit rot_xunit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .opcode_i  (opcode_i),
  .data_i    (data_i),
  .cnt_reg_i (cnt_reg_i),
  .result_o  (result_o),
  .n_o       (n_o),
  .z_o       (z_o),
  .c_o       (c_o),
  .x_o       (x_o)
);

// File: tb/sim_rot_xunit.sv
`timescale 1ns/1ps
module sim_rot_xunit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [31:0] data_i = '0;
  logic [31:0] cnt_reg_i = '0;
  logic [31:0] result_o;
  logic        n_o, z_o, v_o, c_o, x_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit x_m = 1'b0;

  always #2 clk_i = ~clk_i;

  rot_xunit u0 (.*);

  // size 2'b11 = memory form
  function automatic logic [15:0] mk(input logic [2:0] cf, input logic left,
                                     input logic [1:0] sz, input logic regsrc,
                                     input logic plain);
    return {4'hE, cf, left, sz, regsrc, 1'b1, plain, 3'b000};
  endfunction

  // reference: one bit per step
  task automatic model(input logic [15:0] op, input logic [31:0] d, input logic [31:0] cr,
                       input bit xin, output logic [31:0] res, output logic n, output logic z,
                       output logic c, output bit xout);
    int w, raw, k;
    logic [63:0] mask, v;
    bit x, t;
    w    = (op[7:6] == 2'b11) ? 16 : (8 << op[7:6]);
    raw  = (op[7:6] == 2'b11) ? 1 : op[5] ? int'(cr[5:0]) : ((op[11:9] == 0) ? 8 : int'(op[11:9]));
    mask = (64'd1 << w) - 1;
    v    = {32'd0, d} & mask;
    x    = xin;
    if (op[3]) begin
      k = raw % w;
      for (int i = 0; i < k; i++) begin
        if (op[8]) begin t = v[w-1]; v = ((v << 1) | 64'(t)) & mask; end
        else       begin t = v[0];   v = (v >> 1) | (64'(t) << (w-1)); end
      end
      c = (raw == 0) ? 1'b0 : (op[8] ? v[0] : v[w-1]);
    end else begin
      k = raw % (w + 1);
      for (int i = 0; i < k; i++) begin
        if (op[8]) begin t = v[w-1]; v = ((v << 1) | 64'(x)) & mask; x = t; end
        else       begin t = v[0];   v = (v >> 1) | (64'(x) << (w-1)); x = t; end
      end
      c = x;
    end
    xout = x;
    res  = (d & ~mask[31:0]) | v[31:0];
    n    = v[w-1];
    z    = (v == 0);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] op, input logic [31:0] d, input logic [31:0] cr,
                        input bit vld, input string tag);
    logic [31:0] er; logic en, ez, ec; bit ex;
    @(negedge clk_i);
    opcode_i = op; data_i = d; cnt_reg_i = cr; valid_i = vld;
    model(op, d, cr, x_m, er, en, ez, ec, ex);
    #1;
    check({result_o, n_o, z_o, v_o, c_o} == {er, en, ez, 1'b0, ec}, tag,
          64'({result_o, n_o, z_o, v_o, c_o}), 64'({er, en, ez, 1'b0, ec}));
    @(posedge clk_i);
    if (vld && !op[3]) x_m = ex;
    #1;
    check(x_o == x_m, {tag, " R12 x"}, 64'(x_o), 64'(x_m));
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check(x_o == 1'b0, "R12 reset x", 64'(x_o), 64'd0);
  endtask

  task automatic t_plain_imm;
    run_op(mk(3'd3, 1, 2'b00, 0, 1), 32'hABCD_0081, 0, 1, "R1 R8 R10 rol byte 3");
    run_op(mk(3'd0, 0, 2'b10, 0, 1), 32'h1234_5678, 0, 1, "R8 ror long 8");
    run_op(mk(3'd5, 0, 2'b01, 0, 1), 32'hFFFF_8001, 0, 1, "R6 R11 ror word 5");
    check(result_o[31:16] == 16'hFFFF, "R11 word upper", 64'(result_o[31:16]), 64'hFFFF);
  endtask

  task automatic t_plain_reg;
    run_op(mk(3'd0, 1, 2'b00, 1, 1), 32'h0000_00A5, 32'd0, 1, "R6 zero count");
    run_op(mk(3'd0, 1, 2'b00, 1, 1), 32'h0000_00A5, 32'd8, 1, "R1 R6 rol byte 8");
    run_op(mk(3'd0, 0, 2'b01, 1, 1), 32'h5555_0003, 32'hFFFF_FFC1, 1, "R9 mask ror word");
    run_op(mk(3'd0, 1, 2'b10, 1, 1), 32'h8000_0001, 32'd63, 1, "R1 rol long 63");
  endtask

  task automatic t_extend;
    run_op(mk(3'd1, 1, 2'b00, 0, 0), 32'h0000_0080, 0, 1, "R4 roxl byte 1");
    run_op(mk(3'd3, 0, 2'b00, 0, 0), 32'h0000_0012, 0, 1, "R3 roxr byte 3");
    run_op(mk(3'd0, 1, 2'b01, 1, 0), 32'h0000_1234, 32'd17, 1, "R2 R7 roxl word 17");
    run_op(mk(3'd0, 0, 2'b10, 1, 0), 32'hDEAD_BEEF, 32'd33, 1, "R2 roxr long 33");
    run_op(mk(3'd0, 1, 2'b10, 1, 0), 32'h0000_0001, 32'd32, 1, "R4 roxl long 32");
    run_op(mk(3'd0, 0, 2'b00, 1, 0), 32'h0000_00F0, 32'd44, 1, "R2 R3 roxr byte 44");
    run_op(mk(3'd0, 0, 2'b01, 1, 0), 32'h0000_0001, 32'd1, 1, "R3 R7 roxr word 1");
  endtask

  task automatic t_mem;
    run_op(mk(3'd7, 1, 2'b11, 1, 1), 32'hCAFE_8000, 32'd9, 1, "R10 mem rol");
    run_op(mk(3'd7, 0, 2'b11, 1, 0), 32'hCAFE_0001, 32'd9, 1, "R10 R11 mem roxr");
  endtask

  task automatic t_flags;
    run_op(mk(3'd2, 1, 2'b00, 0, 1), 32'hFFFF_FF00, 0, 1, "R5 zero byte");
    run_op(mk(3'd1, 0, 2'b10, 0, 1), 32'h0000_0001, 0, 1, "R5 neg long");
  endtask

  task automatic t_no_update;
    run_op(mk(3'd1, 1, 2'b00, 0, 0), 32'h0000_0080, 0, 1, "R12 set x");
    run_op(mk(3'd1, 1, 2'b00, 0, 0), 32'h0000_0000, 0, 0, "R12 idle extend");
    run_op(mk(3'd1, 1, 2'b00, 0, 1), 32'h0000_0000, 0, 1, "R12 plain keeps x");
    run_op(mk(3'd2, 1, 2'b00, 0, 0), 32'h0000_0000, 0, 1, "R4 roxl byte x in");
  endtask

  initial begin
    #1 t_reset();
    #10 rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    t_plain_imm();
    t_plain_reg();
    t_extend();
    t_mem();
    t_flags();
    t_no_update();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule